// File: doc/BRIEF.md
# Single-Transaction PCI Access Unit

This block gives software a small window of four 32-bit registers on a local register bus. Through it, software can issue one non-prefetchable PCI transaction at a time to an external device: a configuration, memory or I/O read or write. Software first loads the target address. For a write it also loads the outgoing data word. Writing the command register then launches the transaction. The unit holds a request toward a simplified PCI-side agent until that agent acknowledges it. On an acknowledged read, the returned word is captured into a read-back register.

Configuration cycles are type 0 only. The target device is chosen by setting one bit in address bits 31..11, and the unit drives that field out as per-device select lines while a configuration cycle is in flight. If the PCI side gives no acknowledge within a fixed number of clocks, the unit ends the transaction on its own. It then loads all ones as read data and raises a sticky abort flag, which software clears explicitly.

Top module: `npc_access_unit`

## Requirements
- R1: After synchronous reset, all four registers read zero, and `pci_req` is 0 and `pci_dev_sel` is 0.
- R2: The local word index `lb_word` selects the registers as follows: 0 (byte offset 0x0) is the target address, 1 (0x4) is command/status, 2 (0x8) is write data, and 3 (0xC) is read data. Offsets 0, 1 and 2 read back what was written. The read-data register ignores local writes. The command/status word reads as: bits 3:0 the PCI command, bits 7:4 the active-low byte enables, bit 8 busy, bit 9 the abort flag, and all other bits zero.
- R3: A local write to index 1 with bit 9 clear, made while idle, launches a transaction. From the next clock, `pci_req` and the busy bit are 1. `pci_cmd` and `pci_be_n` then carry the written fields, and `pci_wdata` carries the write-data register.
- R4: `pci_write` equals command bit 0. The supported codes are 0010 (I/O read), 0011 (I/O write), 0110 (memory read), 0111 (memory write), 1010 (configuration read) and 1011 (configuration write).
- R5: When `pci_ack` is sampled high during a read command, `pci_rdata` is stored in the read-data register, and `pci_req` and busy are 0 from the next clock.
- R6: An acknowledged write command leaves the read-data register unchanged.
- R7: For configuration commands (1010, 1011), `pci_addr` is the address register with bits 1:0 forced to 00, and `pci_dev_sel[i]` equals address bit 11+i while the request is active. For other commands, `pci_addr` is the full address register. `pci_dev_sel` is 0 whenever no configuration request is active.
- R8: Local writes to any register while busy are ignored, and do not launch a second transaction.
- R9: If `pci_ack` is not sampled high within 16 clocks of request, the request ends after the 16th. The read-data register then becomes 0xFFFFFFFF and the abort flag becomes 1. The flag stays set across later transactions.
- R10: A local write to index 1 with bit 9 set, made while idle, clears the abort flag. It changes neither the command fields nor starts a transaction.
- R11: An acknowledge in the 16th clock of request is still accepted as a normal completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_we | input | 1 | Local register write strobe |
| lb_word | input | 2 | Local register word index (byte offset / 4) |
| lb_wdata | input | 32 | Local write data |
| lb_rdata | output | 32 | Local read data for the selected register |
| pci_req | output | 1 | Transaction request, held until completion |
| pci_cmd | output | 4 | PCI command code |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_addr | output | 32 | PCI address |
| pci_wdata | output | 32 | Outgoing data for write commands |
| pci_write | output | 1 | Transaction direction, 1 = write |
| pci_ack | input | 1 | Completion acknowledge from PCI side |
| pci_rdata | input | 32 | Returned data, valid with acknowledge |
| pci_dev_sel | output | 21 | One line per device during configuration cycles |

## Verification
The hardest state to reach from the ports is the edge of the timeout window. Here an acknowledge arriving in the last permitted clock must complete normally, while one clock later the unit must abort on its own. The bench drives the acknowledge at every delay from zero to fifteen clocks after launch, and also withholds it entirely. It samples the request line and the read-back registers on both sides of the boundary. A second hard case is writing all three registers while a request is pending. The bench holds off the acknowledge, makes those writes, and then reads each register back before releasing the acknowledge.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int DW = 32;

    localparam logic [1:0] W_ADDR  = 2'd0;
    localparam logic [1:0] W_CMD   = 2'd1;
    localparam logic [1:0] W_WDATA = 2'd2;
    localparam logic [1:0] W_RDATA = 2'd3;

    localparam int CLR_BIT = 9;

    localparam logic [3:0] C_IO_RD  = 4'b0010;
    localparam logic [3:0] C_IO_WR  = 4'b0011;
    localparam logic [3:0] C_MEM_RD = 4'b0110;
    localparam logic [3:0] C_MEM_WR = 4'b0111;
    localparam logic [3:0] C_CFG_RD = 4'b1010;
    localparam logic [3:0] C_CFG_WR = 4'b1011;

    typedef enum logic {ST_IDLE, ST_WAIT} npc_state_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [3:0]    cmd;
        logic [3:0]    be_n;
        logic [DW-1:0] wdata;
    } npc_txn_t;

    function automatic logic is_cfg(input logic [3:0] c);
        return c[3:1] == 3'b101;
    endfunction

    function automatic logic is_wr(input logic [3:0] c);
        return c[0];
    endfunction

endpackage

// File: rtl/npc_engine.sv
module npc_engine
    import npc_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic ack,
    output logic busy,
    output logic fin_ok,
    output logic fin_abort
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    npc_state_e    state;
    logic [CW-1:0] cnt;

    assign busy      = (state == ST_WAIT);
    assign fin_ok    = busy && ack;
    assign fin_abort = busy && !ack && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (launch) state <= ST_WAIT;
                end
                default: begin
                    if (fin_ok || fin_abort) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    p_launch_busy_r3: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack && cnt != LAST) |=> busy);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    p_ack_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && ack) |=> !busy);

endmodule

// File: rtl/npc_regs.sv
module npc_regs
    import npc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          lb_we,
    input  logic [1:0]    lb_word,
    input  logic [DW-1:0] lb_wdata,
    output logic [DW-1:0] lb_rdata,
    input  logic          busy,
    input  logic          fin_ok,
    input  logic          fin_abort,
    input  logic [DW-1:0] pci_rdata,
    output logic          launch,
    output npc_txn_t      txn
);
    logic          wr_ok, cmd_wr, clr;
    logic [DW-1:0] rd_q;
    logic          abort_q;

    assign wr_ok  = lb_we && !busy;
    assign cmd_wr = wr_ok && (lb_word == W_CMD);
    assign launch = cmd_wr && !lb_wdata[CLR_BIT];
    assign clr    = cmd_wr && lb_wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            txn     <= '0;
            rd_q    <= '0;
            abort_q <= 1'b0;
        end else begin
            if (wr_ok && lb_word == W_ADDR)  txn.addr  <= lb_wdata;
            if (wr_ok && lb_word == W_WDATA) txn.wdata <= lb_wdata;
            if (launch) begin
                txn.cmd  <= lb_wdata[3:0];
                txn.be_n <= lb_wdata[7:4];
            end
            if (fin_abort) begin
                rd_q    <= '1;
                abort_q <= 1'b1;
            end else if (fin_ok && !is_wr(txn.cmd)) begin
                rd_q <= pci_rdata;
            end
            if (clr) abort_q <= 1'b0;
        end
    end

    always_comb begin
        case (lb_word)
            W_ADDR:  lb_rdata = txn.addr;
            W_CMD:   lb_rdata = {22'b0, abort_q, busy, txn.be_n, txn.cmd};
            W_WDATA: lb_rdata = txn.wdata;
            default: lb_rdata = rd_q;
        endcase
    end

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && lb_we) |=> ($stable(txn.addr) && $stable(txn.wdata)
                             && $stable(txn.cmd) && $stable(txn.be_n)));

    p_abort_ones_r9: assert property (@(posedge clk) disable iff (rst)
        fin_abort |=> (rd_q == '1 && abort_q));

    p_write_keeps_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (fin_ok && is_wr(txn.cmd)) |=> $stable(rd_q));

    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !abort_q);

endmodule

// File: rtl/npc_devsel.sv
module npc_devsel #(
    parameter int AW     = 32,
    parameter int SEL_LO = 11
) (
    input  logic              en,
    input  logic [AW-1:0]     addr,
    output logic [AW-SEL_LO-1:0] sel
);
    localparam int SW = AW - SEL_LO;

    for (genvar i = 0; i < SW; i++) begin : g_sel
        assign sel[i] = en & addr[SEL_LO + i];
    end

endmodule

// File: rtl/npc_access_unit.sv
module npc_access_unit
    import npc_pkg::*;
#(
    parameter int TIMEOUT = 16,
    parameter int SEL_LO  = 11
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lb_we,
    input  logic [1:0]           lb_word,
    input  logic [31:0]          lb_wdata,
    output logic [31:0]          lb_rdata,
    output logic                 pci_req,
    output logic [3:0]           pci_cmd,
    output logic [3:0]           pci_be_n,
    output logic [31:0]          pci_addr,
    output logic [31:0]          pci_wdata,
    output logic                 pci_write,
    input  logic                 pci_ack,
    input  logic [31:0]          pci_rdata,
    output logic [DW-SEL_LO-1:0] pci_dev_sel
);
    logic     launch, busy, fin_ok, fin_abort, cfg;
    npc_txn_t txn;

    npc_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .lb_we     (lb_we),
        .lb_word   (lb_word),
        .lb_wdata  (lb_wdata),
        .lb_rdata  (lb_rdata),
        .busy      (busy),
        .fin_ok    (fin_ok),
        .fin_abort (fin_abort),
        .pci_rdata (pci_rdata),
        .launch    (launch),
        .txn       (txn)
    );

    npc_engine #(.TIMEOUT(TIMEOUT)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .ack       (pci_ack),
        .busy      (busy),
        .fin_ok    (fin_ok),
        .fin_abort (fin_abort)
    );

    assign cfg       = is_cfg(txn.cmd);
    assign pci_req   = busy;
    assign pci_cmd   = txn.cmd;
    assign pci_be_n  = txn.be_n;
    assign pci_wdata = txn.wdata;
    assign pci_write = is_wr(txn.cmd);
    assign pci_addr  = cfg ? {txn.addr[DW-1:2], 2'b00} : txn.addr;

    npc_devsel #(.AW(DW), .SEL_LO(SEL_LO)) u_devsel (
        .en   (busy && cfg),
        .addr (txn.addr),
        .sel  (pci_dev_sel)
    );

    p_type0_r7: assert property (@(posedge clk) disable iff (rst)
        (pci_req && is_cfg(pci_cmd)) |-> (pci_addr[1:0] == 2'b00));

    p_sel_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !pci_req |-> (pci_dev_sel == '0));

    p_req_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (pci_req && !pci_ack) |=> ($stable(pci_addr) && $stable(pci_cmd)));

endmodule

// File: tb/npc_access_unit_bench.sv
module npc_access_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lb_we = 1'b0;
    logic [1:0]  lb_word = 2'd0;
    logic [31:0] lb_wdata = '0;
    logic [31:0] lb_rdata;
    logic        pci_req, pci_write;
    logic [3:0]  pci_cmd, pci_be_n;
    logic [31:0] pci_addr, pci_wdata;
    logic        pci_ack = 1'b0;
    logic [31:0] pci_rdata = '0;
    logic [20:0] pci_dev_sel;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl_rd = '0;
    logic        mdl_ab = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_access_unit u_npc_access_unit (
        .clk(clk), .rst(rst), .lb_we(lb_we), .lb_word(lb_word),
        .lb_wdata(lb_wdata), .lb_rdata(lb_rdata), .pci_req(pci_req),
        .pci_cmd(pci_cmd), .pci_be_n(pci_be_n), .pci_addr(pci_addr),
        .pci_wdata(pci_wdata), .pci_write(pci_write), .pci_ack(pci_ack),
        .pci_rdata(pci_rdata), .pci_dev_sel(pci_dev_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        lb_we = 1'b1; lb_word = w; lb_wdata = d;
        @(negedge clk);
        lb_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        lb_word = w;
        #1 d = lb_rdata;
    endtask

    function automatic logic is_cfg_b(input logic [3:0] c);
        return (c == 4'b1010) || (c == 4'b1011);
    endfunction

    task automatic txn(input logic [31:0] a, input logic [3:0] c, input logic [3:0] be,
                       input logic [31:0] wd, input int dly, input logic [31:0] rv);
        logic [31:0] v;
        wr(2'd0, a);
        wr(2'd2, wd);
        wr(2'd1, {24'b0, be, c});
        chk("R3 req after launch", {31'b0, pci_req}, 32'd1);
        rd(2'd1, v);
        chk("R2 status word busy", v, {22'b0, mdl_ab, 1'b1, be, c});
        chk("R3 cmd out", {28'b0, pci_cmd}, {28'b0, c});
        chk("R3 be out", {28'b0, pci_be_n}, {28'b0, be});
        chk("R3 wdata out", pci_wdata, wd);
        chk("R4 direction", {31'b0, pci_write}, {31'b0, c[0]});
        chk("R7 addr out", pci_addr, is_cfg_b(c) ? {a[31:2], 2'b00} : a);
        chk("R7 dev sel", {11'b0, pci_dev_sel}, is_cfg_b(c) ? {11'b0, a[31:11]} : 32'd0);
        if (dly < 16) begin
            repeat (dly) @(negedge clk);
            pci_ack = 1'b1; pci_rdata = rv;
            @(negedge clk);
            pci_ack = 1'b0;
            chk(dly == 15 ? "R11 late ack completes" : "R5 req drops after ack",
                {31'b0, pci_req}, 32'd0);
            if (!c[0]) mdl_rd = rv;
            rd(2'd3, v);
            chk(c[0] ? "R6 write keeps rdata" : "R5 read data captured", v, mdl_rd);
        end else begin
            repeat (15) @(negedge clk);
            chk("R9 req held before timeout", {31'b0, pci_req}, 32'd1);
            @(negedge clk);
            chk("R9 req ends at timeout", {31'b0, pci_req}, 32'd0);
            mdl_rd = '1; mdl_ab = 1'b1;
            rd(2'd3, v);
            chk("R9 ones on abort", v, 32'hFFFF_FFFF);
        end
        rd(2'd1, v);
        chk("R9 abort flag", {31'b0, v[9]}, {31'b0, mdl_ab});
        chk("R7 sel idle", {11'b0, pci_dev_sel}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [3:0] cmds [6];
        cmds[0] = 4'b0010; cmds[1] = 4'b0011; cmds[2] = 4'b0110;
        cmds[3] = 4'b0111; cmds[4] = 4'b1010; cmds[5] = 4'b1011;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 4; w++) begin
            rd(2'(w), v);
            chk("R1 reset reg", v, 32'd0);
        end
        chk("R1 reset req", {31'b0, pci_req}, 32'd0);
        chk("R1 reset sel", {11'b0, pci_dev_sel}, 32'd0);

        wr(2'd0, 32'hA5A5_0F0F); rd(2'd0, v); chk("R2 addr readback", v, 32'hA5A5_0F0F);
        wr(2'd2, 32'h1234_5678); rd(2'd2, v); chk("R2 wdata readback", v, 32'h1234_5678);
        wr(2'd3, 32'hDEAD_BEEF); rd(2'd3, v); chk("R2 rdata read-only", v, 32'd0);
        chk("R2 no launch by data write", {31'b0, pci_req}, 32'd0);

        for (int c = 0; c < 6; c++) begin
            for (int k = 0; k < 4; k++) begin
                txn(32'h0100_0003 * (c + 1) + (k << 13) + k, cmds[c], 4'(c + k),
                    32'h0F0F_0000 ^ (c * 977 + k), (c * 4 + k) % 16,
                    32'h5000_0000 + c * 64 + k);
            end
        end

        for (int n = 0; n < 21; n++) begin
            txn((32'd1 << (11 + n)) | (n << 2) | 32'd3, 4'b1010, 4'b0000, 32'd0,
                n % 16, 32'h0C00_0000 | n);
        end

        txn(32'h0000_4000, 4'b0110, 4'b0000, 32'd0, 15, 32'h7777_1111);

        wr(2'd0, 32'h0000_1000);
        wr(2'd2, 32'h0000_AAAA);
        wr(2'd1, {24'b0, 4'b0000, 4'b0110});
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd2, 32'h5555_5555);
        wr(2'd1, {24'b0, 4'b1111, 4'b0011});
        rd(2'd0, v); chk("R8 addr ignored while busy", v, 32'h0000_1000);
        rd(2'd2, v); chk("R8 wdata ignored while busy", v, 32'h0000_AAAA);
        rd(2'd1, v); chk("R8 cmd ignored while busy", v, {22'b0, mdl_ab, 1'b1, 4'b0000, 4'b0110});
        pci_ack = 1'b1; pci_rdata = 32'h2468_ACE0;
        @(negedge clk);
        pci_ack = 1'b0;
        mdl_rd = 32'h2468_ACE0;
        @(negedge clk);
        chk("R8 no second launch", {31'b0, pci_req}, 32'd0);
        rd(2'd3, v); chk("R5 data after busy writes", v, mdl_rd);

        txn(32'h0000_2000, 4'b0110, 4'b0000, 32'd0, 16, 32'd0);
        txn(32'h0000_2004, 4'b0111, 4'b0011, 32'hCAFE_0001, 16, 32'd0);
        txn(32'h0000_2008, 4'b0010, 4'b0000, 32'd0, 3, 32'h1357_9BDF);
        rd(2'd1, v); chk("R9 abort sticky", {31'b0, v[9]}, 32'd1);

        wr(2'd1, 32'h0000_0200);
        chk("R10 clear does not launch", {31'b0, pci_req}, 32'd0);
        rd(2'd1, v);
        chk("R10 abort cleared, cmd kept", v, {22'b0, 1'b0, 1'b0, 4'b0000, 4'b0010});
        mdl_ab = 1'b0;
        txn(32'h0000_200C, 4'b0011, 4'b0001, 32'h0000_0042, 0, 32'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule